// File: doc/BRIEF.md
# Temperature-Adaptive Refresh Scheduler

This block decides when an SDRAM controller issues all-bank auto-refresh commands. It keeps a countdown of the refresh interval. When the countdown expires it raises a request to the command scheduler and holds it until the scheduler acknowledges. After each acknowledge, a busy window covers the configured refresh cycle time. During that window the memory may not be used.

The interval is not fixed. At a configurable poll period the block asks the controller to read the device's temperature-status mode register. It decodes the low three bits of the value that comes back into a rate multiplier. A cool device can be refreshed at half or a quarter of the base rate, which cuts the refresh overhead in proportion. A warm device needs two or four times the base rate. If the device reports that an operating limit was exceeded, the block latches an error and falls back to the fastest rate. A new rate is applied only when the next refresh is acknowledged. The period already being counted keeps the deadline it started with.

Top module: `temp_refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `mr_req`, `ref_busy`, `temp_err` and `derate` are low, and the rate is 1x (interval = `cfg_base_interval`) until the first mode-register value is captured.
- R2: `ref_req` rises exactly N cycles after the cycle in which a refresh was acknowledged, where N is the current interval. It stays high until `ref_ack` is seen together with it.
- R3: Rate code 3'b001 gives N = base/4, 3'b010 gives N = base/2, and 3'b011 gives N = base (integer division, base a multiple of 4).
- R4: Rate code 3'b100 gives N = 2*base. Codes 3'b101 and 3'b110 both give N = 4*base.
- R5: `derate` goes high when a captured code is 3'b110 and goes low when any other code is captured.
- R6: Codes 3'b000 and 3'b111 set `temp_err`, which stays high until reset, and select N = base/4.
- R7: A newly captured code changes N only from the refresh acknowledge that follows the capture. The period in progress keeps its old length.
- R8: `ref_busy` is high for exactly `cfg_rfc_cycles` cycles, starting the cycle after a refresh acknowledge.
- R9: `mr_req` rises P+1 cycles after the previous mode-register response, where P is `cfg_poll_period`. It holds until `mr_ack`. The code is bits [2:0] of `mr_data`, and the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_interval | input | TW | 1x refresh interval in cycles (multiple of 4, at least 4) |
| cfg_rfc_cycles | input | TW | Refresh cycle time in cycles |
| cfg_poll_period | input | TW | Cycles between a mode-register response and the next read request |
| mr_req | output | 1 | Request to read the temperature-status mode register |
| mr_ack | input | 1 | Mode-register read data valid; completes the request |
| mr_data | input | MRW | Mode-register value; bits [2:0] are the rate code |
| ref_req | output | 1 | All-bank refresh request |
| ref_ack | input | 1 | Refresh accepted by the command scheduler |
| ref_busy | output | 1 | Device blocked by a refresh in progress |
| temp_err | output | 1 | Sticky: a temperature operating limit was reported |
| derate | output | 1 | Last captured code asked for timing derating |

## Verification
The hardest case to reach from the ports is a rate change that lands in the middle of a period that is already counting. R7 is only visible when the mode-register response arrives after one refresh acknowledge and before the next. The bench changes the code its responder returns right after a refresh acknowledge. The poll period is much shorter than a 1x interval, so the capture is certain to fall inside that period. The bench then measures three consecutive periods: the first must keep the old length, and the third must have the new one. Every one of the eight codes is swept this way, with nonzero upper bits on the mode-register data.

// File: rtl/trs_pkg.sv
// Shared types for the temperature-adaptive refresh scheduler.
package trs_pkg;
    // Refresh rate relative to the base interval.
    typedef enum logic [2:0] {
        RATE_X4      = 3'd0,
        RATE_X2      = 3'd1,
        RATE_X1      = 3'd2,
        RATE_HALF    = 3'd3,
        RATE_QUARTER = 3'd4
    } rate_e;
endpackage

// File: rtl/trs_code_decode.sv
// Decodes the 3-bit temperature rate code into a refresh rate, a limit
// error flag and a derating flag. Purely combinational.
// Assumes: the code has already been taken from the low bits of the register.
module trs_code_decode
    import trs_pkg::*;
(
    input  logic [2:0] code,
    output rate_e      rate,
    output logic       limit_err,
    output logic       need_derate
);
    // Map each code to its rate; the limit codes fall back to the fastest rate.
    always_comb begin
        limit_err   = 1'b0;
        need_derate = 1'b0;
        unique case (code)
            3'b001:  rate = RATE_X4;
            3'b010:  rate = RATE_X2;
            3'b011:  rate = RATE_X1;
            3'b100:  rate = RATE_HALF;
            3'b101:  rate = RATE_QUARTER;
            3'b110: begin
                rate        = RATE_QUARTER;
                need_derate = 1'b1;
            end
            default: begin
                rate      = RATE_X4;
                limit_err = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/trs_poll_seq.sv
// Paces mode-register reads: it counts cfg_poll_period cycles after each
// response, then raises mr_req and holds it until mr_ack.
// Assumes: mr_ack is only meaningful while mr_req is high.
module trs_poll_seq #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] poll_period,
    input  logic          mr_ack,
    output logic          mr_req
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] wait_cnt;
    logic          waiting;

    // Count idle cycles, then wait for the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            waiting  <= 1'b0;
        end else if (waiting) begin
            if (mr_ack) begin
                waiting  <= 1'b0;
                wait_cnt <= '0;
            end
        end else begin
            if (wait_cnt >= poll_period) begin
                waiting <= 1'b1;
            end
            if (wait_cnt != CNT_MAX) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    assign mr_req = waiting;
endmodule

// File: rtl/trs_interval_timer.sv
// Counts cycles since the last refresh acknowledge and requests a refresh
// once the current interval is reached. The rate in use is taken over from
// the pending rate only at an acknowledge. It also times the busy window.
// Assumes: base is a multiple of 4 and at least 4, so no interval is zero.
module trs_interval_timer
    import trs_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] base_interval,
    input  logic [TW-1:0] rfc_cycles,
    input  rate_e         pending_rate,
    input  logic          ref_ack,
    output logic          ref_req,
    output logic          ref_busy
);
    localparam int            CW      = TW + 3;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] elapsed;
    logic [CW-1:0] interval;
    logic [TW-1:0] busy_left;
    rate_e         active_rate;
    logic          accept;

    // Scale the base interval by the rate in use.
    always_comb begin
        unique case (active_rate)
            RATE_X4:      interval = CW'(base_interval) >> 2;
            RATE_X2:      interval = CW'(base_interval) >> 1;
            RATE_HALF:    interval = CW'(base_interval) << 1;
            RATE_QUARTER: interval = CW'(base_interval) << 2;
            default:      interval = CW'(base_interval);
        endcase
    end

    assign ref_req  = (elapsed >= interval);
    assign accept   = ref_req && ref_ack;
    assign ref_busy = (busy_left != '0);

    // Restart the period and load the new rate and busy window on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed     <= '0;
            busy_left   <= '0;
            active_rate <= RATE_X1;
        end else if (accept) begin
            elapsed     <= '0;
            busy_left   <= rfc_cycles;
            active_rate <= pending_rate;
        end else begin
            if (elapsed != CNT_MAX) begin
                elapsed <= elapsed + 1'b1;
            end
            if (busy_left != '0) begin
                busy_left <= busy_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/temp_refresh_sched.sv
// Temperature-adaptive all-bank refresh scheduler. It polls the temperature
// mode register, keeps the decoded rate pending until the next refresh
// boundary, and reports limit errors (sticky) and derating.
// Assumes: configuration inputs are stable while running.
module temp_refresh_sched
    import trs_pkg::*;
#(
    parameter int TW  = 16,
    parameter int MRW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cfg_base_interval,
    input  logic [TW-1:0]  cfg_rfc_cycles,
    input  logic [TW-1:0]  cfg_poll_period,
    output logic           mr_req,
    input  logic           mr_ack,
    input  logic [MRW-1:0] mr_data,
    output logic           ref_req,
    input  logic           ref_ack,
    output logic           ref_busy,
    output logic           temp_err,
    output logic           derate
);
    rate_e dec_rate;
    rate_e pending_rate;
    logic  dec_err;
    logic  dec_derate;
    logic  capture;

    trs_poll_seq #(.TW(TW)) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_period (cfg_poll_period),
        .mr_ack      (mr_ack),
        .mr_req      (mr_req)
    );

    trs_code_decode u_dec (
        .code        (mr_data[2:0]),
        .rate        (dec_rate),
        .limit_err   (dec_err),
        .need_derate (dec_derate)
    );

    assign capture = mr_req && mr_ack;

    // Latch the decoded rate and status when a mode-register value arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_rate <= RATE_X1;
            temp_err     <= 1'b0;
            derate       <= 1'b0;
        end else if (capture) begin
            pending_rate <= dec_rate;
            derate       <= dec_derate;
            if (dec_err) begin
                temp_err <= 1'b1;
            end
        end
    end

    trs_interval_timer #(.TW(TW)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_interval (cfg_base_interval),
        .rfc_cycles    (cfg_rfc_cycles),
        .pending_rate  (pending_rate),
        .ref_ack       (ref_ack),
        .ref_req       (ref_req),
        .ref_busy      (ref_busy)
    );
endmodule

// File: rtl/trs_checker.sv
// Temporal checks on the scheduler's ports, bound to every instance.
module trs_checker #(
    parameter int TW  = 16,
    parameter int MRW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [TW-1:0]  cfg_base_interval,
    input logic [TW-1:0]  cfg_rfc_cycles,
    input logic           mr_req,
    input logic           mr_ack,
    input logic [MRW-1:0] mr_data,
    input logic           ref_req,
    input logic           ref_ack,
    input logic           ref_busy,
    input logic           temp_err,
    input logic           derate
);
    // R2: a pending refresh request is held until acknowledged.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_ack && $stable(cfg_base_interval) |=> ref_req);

    // R2: an accepted request drops in the following cycle.
    a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_ack && (cfg_base_interval >= 4) |=> !ref_req);

    // R8: the busy window opens right after an acknowledge.
    a_r8_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_ack && (cfg_rfc_cycles != 0) |=> ref_busy);

    // R9: the mode-register request is held until answered.
    a_r9_mr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req && !mr_ack |=> mr_req);

    // R6: a limit code raises the error flag.
    a_r6_err_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req && mr_ack && (mr_data[2:0] == 3'b000 || mr_data[2:0] == 3'b111)
        |=> temp_err);

    // R6: the error flag never clears while out of reset.
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        temp_err |=> temp_err);

    // R5: code 110 raises the derating output.
    a_r5_derate_set: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req && mr_ack && (mr_data[2:0] == 3'b110) |=> derate);
endmodule

bind temp_refresh_sched trs_checker #(.TW(TW), .MRW(MRW)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_base_interval (cfg_base_interval),
    .cfg_rfc_cycles    (cfg_rfc_cycles),
    .mr_req            (mr_req),
    .mr_ack            (mr_ack),
    .mr_data           (mr_data),
    .ref_req           (ref_req),
    .ref_ack           (ref_ack),
    .ref_busy          (ref_busy),
    .temp_err          (temp_err),
    .derate            (derate)
);

// File: tb/temp_refresh_sched_tb.sv
// Sweeps every rate code and checks interval lengths, busy window, poll
// spacing and status flags against arithmetic expectations.
module temp_refresh_sched_tb;
    localparam int TW   = 16;
    localparam int MRW  = 8;
    localparam int BASE = 64;
    localparam int RFC  = 5;
    localparam int POLL = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mr_req, ref_req, ref_busy, temp_err, derate;
    logic           mr_ack = 1'b0;
    logic           ref_ack = 1'b0;
    logic [MRW-1:0] mr_data = '0;
    logic [2:0]     resp_code = 3'b011;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit polls_started = 1'b0;

    always #2 clk = ~clk;

    temp_refresh_sched #(.TW(TW), .MRW(MRW)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_base_interval (TW'(BASE)),
        .cfg_rfc_cycles    (TW'(RFC)),
        .cfg_poll_period   (TW'(POLL)),
        .mr_req            (mr_req),
        .mr_ack            (mr_ack),
        .mr_data           (mr_data),
        .ref_req           (ref_req),
        .ref_ack           (ref_ack),
        .ref_busy          (ref_busy),
        .temp_err          (temp_err),
        .derate            (derate)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_interval(input logic [2:0] c);
        case (c)
            3'b001:  return BASE / 4;
            3'b010:  return BASE / 2;
            3'b011:  return BASE;
            3'b100:  return BASE * 2;
            3'b101:  return BASE * 4;
            3'b110:  return BASE * 4;
            default: return BASE / 4;
        endcase
    endfunction

    // Acknowledge one refresh, then return the wait until the next request.
    task automatic service_ref(output int gap, output int busy_n);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        gap    = 0;
        busy_n = ref_busy ? 1 : 0;
        while (!ref_req) begin
            @(negedge clk);
            gap++;
            if (ref_busy) busy_n++;
        end
    endtask

    // Mode-register responder: answers each request one cycle later, upper bits set.
    initial begin
        int w;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (mr_req) begin
                @(negedge clk);
                mr_data = {5'b10101, resp_code};
                mr_ack  = 1'b1;
                @(negedge clk);
                mr_ack  = 1'b0;
                w = 0;
                while (!mr_req && !done) begin
                    @(negedge clk);
                    w++;
                end
                if (!done) check("R9 poll spacing", w, POLL + 1);
            end
        end
    end

    initial begin
        logic [2:0] seq [9] = '{3'b011, 3'b001, 3'b100, 3'b010, 3'b101,
                                 3'b110, 3'b000, 3'b111, 3'b011};
        logic [2:0] prev;
        int gap, busy_n, p1, b1;
        bit err_seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ref_req", int'(ref_req), 0);
        check("R1 mr_req", int'(mr_req), 0);
        check("R1 ref_busy", int'(ref_busy), 0);
        check("R1 temp_err", int'(temp_err), 0);
        check("R1 derate", int'(derate), 0);

        // R1: the first request arrives after the 1x interval from reset.
        gap = 1;
        while (!ref_req) begin
            @(negedge clk);
            gap++;
        end
        check("R1 first interval", gap, BASE);

        // R2: the request is held while no acknowledge is given.
        repeat (3) begin
            @(negedge clk);
            check("R2 req held", int'(ref_req), 1);
        end

        prev = 3'b011;
        err_seen = 1'b0;
        foreach (seq[i]) begin
            resp_code = seq[i];
            service_ref(p1, b1);
            // R8: busy window length
            check("R8 busy cycles", b1, RFC);
            // R7: the period in progress keeps the old interval.
            if (expect_interval(prev) >= BASE)
                check("R7 old interval kept", p1, expect_interval(prev));
            service_ref(gap, busy_n);
            service_ref(gap, busy_n);
            // R3 R4 R6: interval for the new code
            if (seq[i] == 3'b000 || seq[i] == 3'b111)
                check("R6 fallback interval", gap, expect_interval(seq[i]));
            else if (seq[i] >= 3'b100)
                check("R4 slow interval", gap, expect_interval(seq[i]));
            else
                check("R3 fast interval", gap, expect_interval(seq[i]));
            check("R8 busy cycles", busy_n, RFC);
            // R5: derate follows code 110 only
            check("R5 derate", int'(derate), int'(seq[i] == 3'b110));
            if (seq[i] == 3'b000 || seq[i] == 3'b111) err_seen = 1'b1;
            // R6: sticky error
            check("R6 temp_err", int'(temp_err), int'(err_seen));
            prev = seq[i];
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule